// File: doc/BRIEF.md
# Differential Escalation Receiver with Link Ping

This block sits at the far end of a two-wire escalation link. It watches a complementary input pair, splits what it sees into two kinds of traffic by pulse length, and answers on a complementary response pair. A pulse that lasts one cycle is a liveness ping. The receiver answers it with a fixed four-bit response so that the sending side can prove the link works end to end. A pulse that lasts two cycles or more is a real escalation. The receiver raises a local enable level for it and keeps toggling its response for as long as the request is held.

The input pair is checked in every cycle. Equal wire levels are an integrity fault. The receiver mirrors such a fault at once by driving both response wires to the same level, so the sender flags it as well. It then drops back to idle, ready for fresh traffic in the next cycle.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. The response pair is a fixed-latency reply that the sender must sample in the cycles given below.

Top module: `esc_receiver`

## Requirements
- R1: In any cycle where esc_p equals esc_n (integrity fault), resp_n equals resp_p in that same cycle.
- R2: In any cycle where esc_p differs from esc_n, resp_n is the inverse of resp_p.
- R3: While the receiver is idle and the input is not asserted (asserted means esc_p=1, esc_n=0), resp_p is low in the next cycle.
- R4: When the input becomes asserted while the receiver is idle, resp_p is 1 in the following cycle.
- R5: An input asserted for exactly one cycle t (a ping) yields resp_p = 1, 0, 1, 0 in cycles t+1 to t+4, then 0 in t+5 when no new pulse arrives.
- R6: While the input stays asserted in consecutive cycles, resp_p inverts every cycle, starting from 1 in the cycle after the first asserted cycle.
- R7: If the input becomes asserted in cycle t+2 or t+3 of a ping answer, resp_p continues the alternation from its current value instead of restarting at 1.
- R8: esc_en is 1 exactly in those cycles where the input is asserted and was also asserted in the previous cycle. It is 0 in the first cycle the input is no longer asserted.
- R9: A single-cycle ping never raises esc_en.
- R10: After a fault cycle the receiver is idle. A fault cycle counts as not asserted for esc_en, and a pulse in the very next cycle is answered as a fresh ping or escalation.
- R11: During and right after reset, resp_p and esc_en are 0, and resp_n is 1 while the input pair is valid.
- R12: An asserted input in cycle t+4 of a ping answer starts a new answer with resp_p = 1 in t+5, and is then classified as a ping or an escalation by its own length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| esc_p | input | 1 | True wire of the incoming escalation/ping pair |
| esc_n | input | 1 | Complement wire of the incoming pair |
| resp_p | output | 1 | True wire of the response pair |
| resp_n | output | 1 | Complement wire of the response pair; equals resp_p in a fault cycle |
| esc_en | output | 1 | Local escalation enable level |

## Verification
Two functions can act in the same cycle. The first case is an escalation that begins while a ping answer is still running. The second is a fault on the input pair while an answer or an escalation is in progress. Directed sequences start an escalation at each phase of a ping answer (t+2, t+3, t+4) and inject equal wire levels inside pings and inside escalations. A random phase then mixes all input codes cycle by cycle. A behavioural model in the bench, built from a queue of pending ping bits, predicts resp_p, resp_n and esc_en for every cycle. The bench judges both the continued phase and the immediate return to idle against that model.

// File: rtl/esc_rx_pkg.sv
package esc_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE    = 3'd0,
    RX_FIRST   = 3'd1,
    RX_PING_B1 = 3'd2,
    RX_PING_B2 = 3'd3,
    RX_PING_B3 = 3'd4,
    RX_ESC_LO  = 3'd5,
    RX_ESC_HI  = 3'd6
  } rx_state_e;

  // Response level each state presents on the true response wire.
  function automatic logic state_resp(rx_state_e s);
    case (s)
      RX_FIRST, RX_PING_B2, RX_ESC_HI: state_resp = 1'b1;
      default:                         state_resp = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/esc_rx_wire_decode.sv
module esc_rx_wire_decode (
  input  logic wire_p,
  input  logic wire_n,
  output logic asserted,
  output logic fault
);
  // Valid only when complementary; a fault masks the level.
  assign fault    = ~(wire_p ^ wire_n);
  assign asserted = wire_p & ~wire_n;
endmodule

// File: rtl/esc_rx_pulse_track.sv
module esc_rx_pulse_track (
  input  logic clk,
  input  logic rst_n,
  input  logic asserted,
  output logic prev_asserted,
  output logic enable
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= asserted;
  end

  // Second and later consecutive asserted cycles mean escalation.
  assign enable        = asserted & seen_q;
  assign prev_asserted = seen_q;
endmodule

// File: rtl/esc_rx_handshake.sv
module esc_rx_handshake
  import esc_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      asserted,
  input  logic      fault,
  output logic      resp_level,
  output rx_state_e state
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RX_IDLE:    state_d = asserted ? RX_FIRST   : RX_IDLE;
      RX_FIRST:   state_d = asserted ? RX_ESC_LO  : RX_PING_B1;
      RX_PING_B1: state_d = asserted ? RX_ESC_HI  : RX_PING_B2;
      RX_PING_B2: state_d = asserted ? RX_ESC_LO  : RX_PING_B3;
      RX_PING_B3: state_d = asserted ? RX_FIRST   : RX_IDLE;
      RX_ESC_LO:  state_d = asserted ? RX_ESC_HI  : RX_IDLE;
      RX_ESC_HI:  state_d = asserted ? RX_ESC_LO  : RX_IDLE;
      default:    state_d = RX_IDLE;
    endcase
    if (fault) state_d = RX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  assign resp_level = state_resp(state_q);
  assign state      = state_q;
endmodule

// File: rtl/esc_rx_resp_drive.sv
module esc_rx_resp_drive (
  input  logic level,
  input  logic fault,
  output logic out_p,
  output logic out_n
);
  // Complementary normally; equal levels mirror a detected fault.
  assign out_p = level;
  assign out_n = fault ? level : ~level;
endmodule

// File: rtl/esc_receiver.sv
module esc_receiver
  import esc_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic esc_p,
  input  logic esc_n,
  output logic resp_p,
  output logic resp_n,
  output logic esc_en
);
  logic      in_asserted;
  logic      in_fault;
  logic      resp_level;
  logic      prev_asserted;
  rx_state_e hs_state;

  esc_rx_wire_decode u_dec (
    .wire_p   (esc_p),
    .wire_n   (esc_n),
    .asserted (in_asserted),
    .fault    (in_fault)
  );

  esc_rx_pulse_track u_trk (
    .clk           (clk),
    .rst_n         (rst_n),
    .asserted      (in_asserted),
    .prev_asserted (prev_asserted),
    .enable        (esc_en)
  );

  esc_rx_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .asserted   (in_asserted),
    .fault      (in_fault),
    .resp_level (resp_level),
    .state      (hs_state)
  );

  esc_rx_resp_drive u_drv (
    .level (resp_level),
    .fault (in_fault),
    .out_p (resp_p),
    .out_n (resp_n)
  );
endmodule

// File: rtl/esc_receiver_sva.sv
module esc_receiver_sva
  import esc_rx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      esc_p,
  input logic      esc_n,
  input logic      resp_p,
  input logic      resp_n,
  input logic      esc_en,
  input rx_state_e state,
  input logic      prev_asserted
);
  assert_fault_mirror_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_p == esc_n) |-> (resp_p == resp_n));

  assert_diff_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_p != esc_n) |-> (resp_p != resp_n));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && !(esc_p && !esc_n)) |=> !resp_p);

  assert_first_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && esc_p && !esc_n) |=> resp_p);

  assert_ping_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_FIRST && !esc_p && esc_n) |=> !resp_p);

  assert_ping_third_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_PING_B1 && !esc_p && esc_n) |=> resp_p);

  assert_esc_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_p && !esc_n && prev_asserted) |=> (resp_p != $past(resp_p)));

  assert_phase_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_PING_B2 && esc_p && !esc_n) |=> (!resp_p && state == RX_ESC_LO));

  assert_en_needs_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    esc_en |-> (esc_p && !esc_n));

  assert_en_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esc_en) |-> prev_asserted);

  assert_fault_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_p == esc_n) |=> (state == RX_IDLE && !resp_p));
endmodule

bind esc_receiver esc_receiver_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .esc_p         (esc_p),
  .esc_n         (esc_n),
  .resp_p        (resp_p),
  .resp_n        (resp_n),
  .esc_en        (esc_en),
  .state         (hs_state),
  .prev_asserted (prev_asserted)
);

// File: tb/sim_esc_receiver.sv
`timescale 1ns/1ps
module sim_esc_receiver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic esc_p = 1'b0;
  logic esc_n = 1'b1;
  logic resp_p, resp_n, esc_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Behavioural model: 0 idle, 1 first bit given, 2 ping answer, 3 escalation
  int    mode = 0;
  bit    exp_r = 1'b0;
  bit    prev_a = 1'b0;
  bit    ping_q[$];
  string tag_r = "R3";

  always #4 clk = ~clk;

  esc_receiver u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .esc_p  (esc_p),
    .esc_n  (esc_n),
    .resp_p (resp_p),
    .resp_n (resp_n),
    .esc_en (esc_en)
  );

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic evaluate();
    bit    f;
    bit    a;
    string en_tag;
    f = (esc_p == esc_n);
    a = esc_p && !esc_n;
    en_tag = (mode == 2 || (mode == 1 && !a)) ? "R9" : "R8";
    check(tag_r, resp_p, exp_r);
    check(f ? "R1" : "R2", resp_n, f ? exp_r : !exp_r);
    check(en_tag, esc_en, a && prev_a);
    if (f) begin
      mode = 0; exp_r = 1'b0; ping_q.delete(); tag_r = "R10";
    end else begin
      case (mode)
        0: if (a) begin exp_r = 1'b1; mode = 1; tag_r = "R4"; end
           else   begin exp_r = 1'b0; tag_r = "R3"; end
        1: if (a) begin exp_r = 1'b0; mode = 3; tag_r = "R6"; end
           else begin
             ping_q.delete(); ping_q.push_back(1'b1); ping_q.push_back(1'b0);
             exp_r = 1'b0; mode = 2; tag_r = "R5";
           end
        2: if (a) begin
             if (ping_q.size() == 0) begin exp_r = 1'b1; mode = 1; tag_r = "R12"; end
             else begin exp_r = !exp_r; ping_q.delete(); mode = 3; tag_r = "R7"; end
           end else begin
             if (ping_q.size() > 0) begin exp_r = ping_q.pop_front(); tag_r = "R5"; end
             else begin exp_r = 1'b0; mode = 0; tag_r = "R3"; end
           end
        default: if (a) begin exp_r = !exp_r; tag_r = "R6"; end
                 else   begin exp_r = 1'b0; mode = 0; tag_r = "R3"; end
      endcase
    end
    prev_a = a;
  endtask

  task automatic step(bit p, bit n);
    @(posedge clk); #1;
    esc_p = p; esc_n = n;
    @(negedge clk);
    evaluate();
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) step(1'b0, 1'b1);
  endtask

  task automatic assert_for(int k);
    for (int i = 0; i < k; i++) step(1'b1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11", resp_p, 1'b0);
      check("R11", resp_n, 1'b1);
      check("R11", esc_en, 1'b0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R11", resp_p, 1'b0);
    check("R11", resp_n, 1'b1);
    check("R11", esc_en, 1'b0);

    idle(4);
    assert_for(1); idle(6);                 // R5 plain ping, R9
    assert_for(5); idle(3);                 // R6, R8 escalation
    assert_for(1); idle(1); assert_for(4); idle(3);   // R7 onset at t+2
    assert_for(1); idle(2); assert_for(3); idle(3);   // R7 onset at t+3
    assert_for(1); idle(3); assert_for(1); idle(6);   // R12 ping at t+4
    assert_for(1); idle(3); assert_for(3); idle(3);   // R12 escalation at t+4
    step(1'b1, 1'b1); assert_for(1); idle(5);         // R1, R10 fault then ping
    assert_for(3); step(1'b0, 1'b0); assert_for(3); idle(3); // R10 fault inside escalation
    assert_for(1); idle(1); step(1'b1, 1'b1); idle(1); assert_for(1); idle(5);
    assert_for(2); idle(3);

    for (int i = 0; i < 600; i++) begin
      int c;
      c = $urandom_range(0, 11);
      if (c < 5)       step(1'b0, 1'b1);
      else if (c < 10) step(1'b1, 1'b0);
      else if (c == 10) step(1'b1, 1'b1);
      else             step(1'b0, 1'b0);
    end
    idle(6);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R1-all: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule